// File: doc/BRIEF.md
# Outstanding Read ID Tracker

This block sits between the cache-side issuing logic and the memory controller's read channel and assigns a tag to every read. When the issuing logic offers an address, the tracker picks the lowest-numbered free tag out of eight. It presents the address and tag on the request channel and keeps them there until the controller acknowledges. The tag stays busy until its data has come back.

Read data returns as four beats, and each beat carries the tag of its request. The tracker counts beats separately for each tag, so returns for different tags may interleave freely. A tag is released only on the fourth beat that carries it. A beat whose tag is not busy is a protocol error and raises a one-cycle error pulse. An offer made while all eight tags are busy is refused through a low ready, and it also raises its own one-cycle error pulse. The busy map of all tags is visible at all times.

Top module: `rid_tracker`

## Requirements
- R1: After reset, `busy_map` is all zero, `mem_req`, `ret_err` and `issue_err` are low, and `issue_ready` is high.
- R2: An accepted offer (`issue_valid` and `issue_ready` both high at a clock edge) is given the lowest-numbered tag whose `busy_map` bit is 0. The tag is 3 bits wide, tag n maps to `busy_map[n]`, and the tag's bit is set from the next cycle on.
- R3: A busy tag is never handed out again until it has been released, so each tag has at most one outstanding request.
- R4: A tag is released (its bit cleared in the cycle after the beat) on the fourth beat that has `ret_valid` high with `ret_id` equal to that tag. Beats are counted per tag, and beats for other tags do not disturb the count.
- R5: A beat whose `ret_id` is not busy raises `ret_err` for exactly one cycle, in the cycle after the beat, and it leaves `busy_map` unchanged.
- R6: `mem_req` rises in the cycle after acceptance with `mem_req_addr` equal to the offered address and `mem_req_id` equal to the assigned tag. All three hold steady until a cycle with `mem_ack` high, and `mem_req` is low in the cycle after that.
- R7: While all eight tags are busy, `issue_ready` is low and no request is issued. An offer in that state raises `issue_err` for one cycle, in the cycle after the offer.
- R8: While `mem_req` is high, `mem_req_addr` and `mem_req_id` carry known values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Issuing logic offers a read |
| issue_addr | input | ADDR_W | Address of the offered read |
| issue_ready | output | 1 | A tag is free and the request channel can take a request |
| mem_req | output | 1 | Read request toward memory, held until acknowledged |
| mem_req_addr | output | ADDR_W | Address of the pending request |
| mem_req_id | output | ID_W | Tag of the pending request |
| mem_ack | input | 1 | Memory acknowledges the pending request |
| ret_valid | input | 1 | A tagged data beat is returning |
| ret_id | input | ID_W | Tag carried by the returning beat |
| busy_map | output | NUM_IDS | One bit per tag, 1 while outstanding |
| ret_err | output | 1 | One-cycle pulse for a beat with a non-busy tag |
| issue_err | output | 1 | One-cycle pulse for an offer made while all tags are busy |

## Verification
The embedded assertions watch every cycle for these properties. A held request keeps its address and tag stable until acknowledged, and those fields are never unknown while it is up. A tag is never allocated while busy, the allocation one-hot never has two bits set, a full busy map always forces ready low, and every beat on a non-busy tag is followed by an error pulse. The following can only be shown by the bench's scenarios, which compare against a model of busy bits and beat counts: that the lowest free tag is the one chosen, and that release happens on exactly the fourth beat when returns for different tags interleave in varied orders. The same holds for refilling freed tags out of order and for error pulses lasting exactly one cycle.

// File: rtl/rid_pkg.sv
package rid_pkg;
  localparam int RID_COUNT     = 8;
  localparam int RID_BEATS     = 4;
  localparam int RID_ADDR_BITS = 16;

  // Beat index that completes a tagged return of the given length.
  function automatic int final_beat(input int beats);
    return beats - 1;
  endfunction

  // Beat counter successor, wrapping after the final beat.
  function automatic int beat_succ(input int cur, input int beats);
    return (cur >= final_beat(beats)) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/rid_pick.sv
module rid_pick #(
  parameter int N  = rid_pkg::RID_COUNT,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  free_vec,
  output logic          any_free,
  output logic [N-1:0]  pick_onehot,
  output logic [IW-1:0] pick_id
);
  // lower_free[i] is high when any tag below i is free
  logic [N:0] lower_free;
  assign lower_free[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chain
      assign lower_free[g+1]  = lower_free[g] | free_vec[g];
      assign pick_onehot[g]   = free_vec[g] & ~lower_free[g];
    end
  endgenerate

  assign any_free = lower_free[N];

  always_comb begin
    pick_id = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) pick_id = IW'(i);
    end
  end

  always_comb begin
    if (!$isunknown(free_vec)) begin
      a_r2_pick_onehot: assert ($onehot0(pick_onehot))
        else $error("R2: more than one tag chosen");
      a_r2_pick_agrees: assert (!any_free || pick_onehot[pick_id])
        else $error("R2: encoded tag and one-hot disagree");
    end
  end
endmodule

// File: rtl/rid_slot.sv
module rid_slot #(
  parameter int BEATS = rid_pkg::RID_BEATS,
  parameter int CW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alloc,
  input  logic beat_hit,
  output logic busy,
  output logic retire
);
  logic [CW-1:0] beat_cnt;
  logic          last_beat;

  assign last_beat = (beat_cnt == CW'(rid_pkg::final_beat(BEATS)));
  assign retire    = beat_hit & busy & last_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      beat_cnt <= '0;
    end else if (alloc) begin
      busy     <= 1'b1;
      beat_cnt <= '0;
    end else if (beat_hit && busy) begin
      busy     <= ~last_beat;
      beat_cnt <= CW'(rid_pkg::beat_succ(int'(beat_cnt), BEATS));
    end
  end

  a_r3_no_realloc: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !busy)
    else $error("R3: busy tag allocated again");

  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !busy)
    else $error("R4: tag still busy after final beat");

  a_r4_no_early_release: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !retire) |=> busy)
    else $error("R4: tag released before final beat");
endmodule

// File: rtl/rid_hold.sv
module rid_hold #(
  parameter int AW = rid_pkg::RID_ADDR_BITS,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [IW-1:0] load_id,
  input  logic          ack,
  output logic          req,
  output logic [AW-1:0] req_addr,
  output logic [IW-1:0] req_id
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req      <= 1'b0;
      req_addr <= '0;
      req_id   <= '0;
    end else if (load) begin
      req      <= 1'b1;
      req_addr <= load_addr;
      req_id   <= load_id;
    end else if (ack) begin
      req      <= 1'b0;
    end
  end

  a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(req_addr) && $stable(req_id)))
    else $error("R6: request changed before acknowledge");

  a_r6_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack && !load) |=> !req)
    else $error("R6: request not dropped after acknowledge");

  a_r8_known_fields: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> !$isunknown({req_addr, req_id}))
    else $error("R8: unknown address or tag on request");
endmodule

// File: rtl/rid_tracker.sv
module rid_tracker #(
  parameter int NUM_IDS = rid_pkg::RID_COUNT,
  parameter int BEATS   = rid_pkg::RID_BEATS,
  parameter int ADDR_W  = rid_pkg::RID_ADDR_BITS,
  parameter int ID_W    = $clog2(NUM_IDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_valid,
  input  logic [ADDR_W-1:0]  issue_addr,
  output logic               issue_ready,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic [ID_W-1:0]    mem_req_id,
  input  logic               mem_ack,
  input  logic               ret_valid,
  input  logic [ID_W-1:0]    ret_id,
  output logic [NUM_IDS-1:0] busy_map,
  output logic               ret_err,
  output logic               issue_err
);
  logic [NUM_IDS-1:0] busy_vec;
  logic [NUM_IDS-1:0] free_vec;
  logic [NUM_IDS-1:0] pick_onehot;
  logic [NUM_IDS-1:0] alloc_vec;
  logic [NUM_IDS-1:0] hit_vec;
  logic [NUM_IDS-1:0] retire_vec;
  logic [ID_W-1:0]    pick_id;
  logic               any_free;
  logic               accept;
  logic               ret_bad;
  logic               offer_full;

  assign free_vec    = ~busy_vec;
  assign issue_ready = any_free & (~mem_req | mem_ack);
  assign accept      = issue_valid & issue_ready;
  assign alloc_vec   = accept ? pick_onehot : '0;
  assign ret_bad     = ret_valid & ~busy_vec[ret_id];
  assign offer_full  = issue_valid & ~any_free;
  assign busy_map    = busy_vec;

  rid_pick #(.N(NUM_IDS), .IW(ID_W)) u_pick (
    .free_vec    (free_vec),
    .any_free    (any_free),
    .pick_onehot (pick_onehot),
    .pick_id     (pick_id)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_IDS; g++) begin : g_slot
      assign hit_vec[g] = ret_valid & (ret_id == ID_W'(g));
      rid_slot #(.BEATS(BEATS)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc    (alloc_vec[g]),
        .beat_hit (hit_vec[g]),
        .busy     (busy_vec[g]),
        .retire   (retire_vec[g])
      );
    end
  endgenerate

  rid_hold #(.AW(ADDR_W), .IW(ID_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_addr (issue_addr),
    .load_id   (pick_id),
    .ack       (mem_ack),
    .req       (mem_req),
    .req_addr  (mem_req_addr),
    .req_id    (mem_req_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_err   <= 1'b0;
      issue_err <= 1'b0;
    end else begin
      ret_err   <= ret_bad;
      issue_err <= offer_full;
    end
  end

  a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy_map) |-> !issue_ready)
    else $error("R7: ready high with all tags busy");

  a_r7_full_offer_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && (&busy_map)) |=> issue_err)
    else $error("R7: refused offer not flagged");

  a_r5_bad_return_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !busy_map[ret_id]) |=> (ret_err && busy_map == $past(busy_map)))
    else $error("R5: stray beat not flagged or changed state");

  a_r5_good_return_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && busy_map[ret_id]) |=> !ret_err)
    else $error("R5: error raised on a valid beat");

  a_r2_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> busy_map[mem_req_id])
    else $error("R2: issued tag not marked busy");
endmodule

// File: tb/tb_rid_tracker.sv
module tb_rid_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 16;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          issue_valid = 1'b0;
  logic [AW-1:0] issue_addr = '0;
  logic          issue_ready;
  logic          mem_req;
  logic [AW-1:0] mem_req_addr;
  logic [IW-1:0] mem_req_id;
  logic          mem_ack = 1'b0;
  logic          ret_valid = 1'b0;
  logic [IW-1:0] ret_id = '0;
  logic [N-1:0]  busy_map;
  logic          ret_err;
  logic          issue_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit mbusy [N];
  int mcnt  [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  rid_tracker dut (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_addr(issue_addr), .issue_ready(issue_ready),
    .mem_req(mem_req), .mem_req_addr(mem_req_addr), .mem_req_id(mem_req_id),
    .mem_ack(mem_ack), .ret_valid(ret_valid), .ret_id(ret_id),
    .busy_map(busy_map), .ret_err(ret_err), .issue_err(issue_err)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] model_map();
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = mbusy[i];
    return m;
  endfunction

  function automatic int model_lowest();
    for (int i = 0; i < N; i++) if (!mbusy[i]) return i;
    return -1;
  endfunction

  // Offer one read, hold off the acknowledge for wait_cycles cycles.
  task automatic issue(input logic [AW-1:0] addr, input int wait_cycles);
    int exp_id;
    exp_id = model_lowest();
    @(negedge clk);
    check("R2 ready before offer", issue_ready, 1);
    issue_valid = 1'b1;
    issue_addr  = addr;
    @(negedge clk);
    issue_valid = 1'b0;
    mbusy[exp_id] = 1'b1;
    mcnt[exp_id]  = 0;
    check("R6 request raised", mem_req, 1);
    check("R6 request address", mem_req_addr, addr);
    check("R2 lowest free tag", mem_req_id, exp_id);
    check("R3 busy map after allocate", busy_map, model_map());
    for (int w = 0; w < wait_cycles; w++) begin
      @(negedge clk);
      check("R6 held without ack", {mem_req, mem_req_addr, mem_req_id},
            {1'b1, addr, IW'(exp_id)});
    end
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    check("R6 dropped after ack", mem_req, 0);
  endtask

  // Return one tagged beat and compare against the model.
  task automatic beat(input int id);
    bit exp_err;
    exp_err = !mbusy[id];
    if (!exp_err) begin
      mcnt[id]++;
      if (mcnt[id] == 4) begin
        mbusy[id] = 1'b0;
        mcnt[id]  = 0;
      end
    end
    @(negedge clk);
    ret_valid = 1'b1;
    ret_id    = IW'(id);
    @(negedge clk);
    ret_valid = 1'b0;
    check(exp_err ? "R5 stray beat error" : "R4 valid beat no error", ret_err, exp_err);
    check("R4 busy map after beat", busy_map, model_map());
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin mbusy[i] = 1'b0; mcnt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy_map reset", busy_map, 0);
    check("R1 mem_req reset", mem_req, 0);
    check("R1 errors reset", {ret_err, issue_err}, 0);
    check("R1 ready reset", issue_ready, 1);

    // R2 fill all tags in order
    for (int k = 0; k < N; k++) issue(AW'(k * 16'h1111 + 5), k % 3);

    // R7 full: refusal and error pulse
    @(negedge clk);
    check("R7 ready low when full", issue_ready, 0);
    issue_valid = 1'b1;
    issue_addr  = 16'hdead;
    @(negedge clk);
    issue_valid = 1'b0;
    check("R7 issue_err pulse", issue_err, 1);
    check("R7 no request when full", mem_req, 0);
    @(negedge clk);
    check("R7 issue_err one cycle", issue_err, 0);

    // R4 interleaved returns on tags 5 and 2, then refill (R3/R2)
    for (int b = 0; b < 4; b++) begin beat(5); beat(2); end
    issue(16'h0a0a, 1);
    check("R2 refill picks tag 2 first", mem_req_id, 2);
    issue(16'h0b0b, 0);
    check("R2 refill picks tag 5 next", mem_req_id, 5);

    // R4 sweep: every round returns one beat per tag in a permuted order
    for (int b = 0; b < 4; b++)
      for (int j = 0; j < N; j++) beat((j * 3 + b) % N);
    check("R4 all tags released", busy_map, 0);

    // R5 stray beats on every tag
    for (int j = 0; j < N; j++) beat(j);
    @(negedge clk);
    check("R5 ret_err one cycle", ret_err, 0);

    // R5 stray among busy tags
    issue(16'h1234, 2);
    issue(16'h5678, 0);
    issue(16'h9abc, 1);
    beat(4);
    beat(1);
    beat(6);
    check("R3 busy map after mix", busy_map, 8'b0000_0111);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule